// File: doc/BRIEF.md
# Daisy-Chainable Serial Result Shifter

This block is the output stage of a converter that is read as a serial slave. It holds one result word and shifts it out most significant bit first on a serial clock supplied by the host. The host's serial clock, chip-select and read-enable are oversampled: a two-flop synchroniser brings each into the system clock domain, and edges are detected there. The system clock must run at least four times faster than the serial clock. The serial output is enabled only while chip-select and read-enable are both low. When it is not enabled, the enable pin is low and the line may be treated as high-impedance.

A new result enters through a valid/ready load port. Each transfer is one word. `load_ready` is high whenever no read is active. A word offered while `load_ready` is low is not taken, and it has no effect on the word being read. The block has no buffer, so a producer that must not lose a result keeps `load_valid` high until it sees `load_ready`.

Several devices can be chained. The chain input is sampled on the serial clock edge opposite to the edge that shifts the register, and it feeds the vacated bottom bit. As a result, the first bit of the upstream device follows this device's last bit with no gap. The serial clock may run continuously or in bursts, and it may rest high or low while idle.

Top module: `ser_result_shifter`

## Requirements
- R1: After reset, `sdo_en` is 0, `sdo` is 0 and `load_ready` is 1.
- R2: A word accepted on the load port (`load_valid` and `load_ready` both high at a clock edge) becomes the next word read, with bit 15 on `sdo` as soon as the output is enabled.
- R3: With the default `SHIFT_ON_RISE = 0`, each falling serial clock edge during an active read advances `sdo` by one bit, so 16 edges deliver bits 15 down to 0 in order.
- R4: `sdo_en` is 1 while `cs_n_in` and `rd_n_in` are both 0, and is 0 while either of them is 1. Each change takes effect three system clock edges later.
- R5: Serial clock edges that occur while `cs_n_in` or `rd_n_in` is 1 leave the stored word unchanged.
- R6: The chain input is sampled on rising serial clock edges during a read. After the local bit 0, the upstream bits appear on `sdo` on the following falling edges, upstream bit 15 first.
- R7: `load_ready` is 0 during an active read. A word offered then is ignored, and the word being read is unchanged.
- R8: Between two shift edges `sdo` holds its value, so a host may sample it at either serial clock edge.
- R9: When the serial clock rests high as the read starts, the first falling edge does not shift. Shifting begins only after a rising edge has been seen within the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| cs_n_in | input | 1 | Chip-select, active low, asynchronous |
| rd_n_in | input | 1 | Read-enable, active low, asynchronous |
| chain_in | input | 1 | Serial data from the upstream device |
| load_valid | input | 1 | Result word offered on `load_data` |
| load_ready | output | 1 | Block can take a result word (no read active) |
| load_data | input | 16 | Result word |
| sdo | output | 1 | Serial data, forced to 0 while not enabled |
| sdo_en | output | 1 | Output enable for the serial data line |

## Verification
A load and the start of a read can fall on the same system clock edge: the edge on which the synchronised selects make the read active is also the last edge on which `load_ready` is still high. The bench holds `load_valid` high with one word across the chip-select fall, then switches to a second word once `load_ready` has dropped. It requires that the read deliver the first word and that `load_ready` be low at that point. Separately, it checks that a load offered in the middle of a read does not disturb the bits that follow.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int RESULT_W = 16;

  // serial clock events after synchronisation, qualified by an active read
  typedef struct packed {
    logic capture;  // chain-sampling edge
    logic shift;    // output-advancing edge
  } clk_evt_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srs_edge.sv
module srs_edge
  import srs_pkg::*;
#(
  parameter bit SHIFT_ON_RISE = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sclk_s,
  input  logic     active,
  output clk_evt_t evt
);
  logic sclk_d, armed;
  logic rise, fall, cap_e, sh_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  generate
    if (SHIFT_ON_RISE) begin : g_rise_shift
      assign cap_e = fall;
      assign sh_e  = rise;
    end else begin : g_fall_shift
      assign cap_e = rise;
      assign sh_e  = fall;
    end
  endgenerate

  // a shift edge counts only after a capture edge in the same read (R9)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed <= 1'b0;
    else if (!active)          armed <= 1'b0;
    else if (cap_e)            armed <= 1'b1;
  end

  assign evt.capture = active & cap_e;
  assign evt.shift   = active & sh_e & armed;
endmodule

// File: rtl/srs_shreg.sv
module srs_shreg
  import srs_pkg::*;
#(
  parameter int W = RESULT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_word,
  input  clk_evt_t     evt,
  input  logic         chain_s,
  output logic [W-1:0] sr_q,
  output logic         chain_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= '0;
    else if (load_en)    sr_q <= load_word;
    else if (evt.shift)  sr_q <= {sr_q[W-2:0], chain_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            chain_q <= 1'b0;
    else if (evt.capture)  chain_q <= chain_s;
  end
endmodule

// File: rtl/ser_result_shifter.sv
module ser_result_shifter
  import srs_pkg::*;
#(
  parameter int DATA_W        = RESULT_W,
  parameter int SYNC_STAGES   = 2,
  parameter bit SHIFT_ON_RISE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              cs_n_in,
  input  logic              rd_n_in,
  input  logic              chain_in,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [DATA_W-1:0] load_data,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int NSYNC = 4;
  // order {sclk, cs_n, rd_n, chain}; selects rest inactive
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0110;

  logic [NSYNC-1:0] raw_in, syn;
  logic sclk_s, cs_s, rd_s, chain_s;
  logic act_q, load_en, chain_q;
  logic [DATA_W-1:0] sr_q;
  clk_evt_t evt;

  assign raw_in = {sclk_in, cs_n_in, rd_n_in, chain_in};

  srs_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign {sclk_s, cs_s, rd_s, chain_s} = syn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= ~cs_s & ~rd_s;
  end

  srs_edge #(.SHIFT_ON_RISE(SHIFT_ON_RISE)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .active(act_q), .evt(evt)
  );

  assign load_ready = ~act_q;
  assign load_en    = load_valid & load_ready;

  srs_shreg #(.W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_word(load_data),
    .evt(evt), .chain_s(chain_s), .sr_q(sr_q), .chain_q(chain_q)
  );

  assign sdo_en = act_q;
  assign sdo    = act_q & sr_q[DATA_W-1];
endmodule

// File: rtl/srs_chk.sv
module srs_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_valid,
  input logic         load_ready,
  input logic         sdo,
  input logic         sdo_en,
  input logic [W-1:0] sr_q,
  input logic         chain_q,
  input logic         shift_ev
);
  // R7
  load_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && !load_ready && !shift_ev) |=> $stable(sr_q));

  // R3
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> (sr_q == {$past(sr_q[W-2:0]), $past(chain_q)}));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_en && !(load_valid && load_ready)) |=> $stable(sr_q));

  // R8
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && !shift_ev) ##1 sdo_en |-> $stable(sdo));
endmodule

bind ser_result_shifter srs_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
  .sdo(sdo), .sdo_en(sdo_en), .sr_q(sr_q), .chain_q(chain_q),
  .shift_ev(evt.shift)
);

// File: tb/ser_result_shifter_tb.sv
module ser_result_shifter_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk_in = 1'b0, cs_n_in = 1'b1, rd_n_in = 1'b1, chain_in = 1'b0;
  logic load_valid = 1'b0;
  logic [15:0] load_data = '0;
  logic load_ready, sdo, sdo_en;

  int total = 0, bad = 0;
  bit exp_q[$];
  string req_q[$];
  event samp_ev;

  always #5 clk = ~clk;

  ser_result_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .cs_n_in(cs_n_in),
    .rd_n_in(rd_n_in), .chain_in(chain_in), .load_valid(load_valid),
    .load_ready(load_ready), .load_data(load_data), .sdo(sdo), .sdo_en(sdo_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected bit per host sample point (R8 via paired samples)
  always @(samp_ev) begin
    bit e;
    string r;
    if (exp_q.size() == 0) begin
      chk(1'b0, "scoreboard-empty", 0, 1);
    end else begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(sdo_en === 1'b1, "R4 enable during read", int'(sdo_en), 1);
      chk(sdo === e, r, int'(sdo), int'(e));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk);
    load_valid = 1'b1;
    load_data  = w;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  // driver: queues expected bits, then clocks the read
  task automatic do_read(input logic [47:0] exp_s, input logic [47:0] up_s,
                         input int nbits, input bit idle_high, input string req);
    for (int i = 0; i < nbits; i++) begin
      exp_q.push_back(exp_s[47-i]); req_q.push_back(req);   // before capture edge
      exp_q.push_back(exp_s[47-i]); req_q.push_back({req, " R8"}); // before shift edge
    end
    sclk_in = idle_high;
    chain_in = up_s[47];
    tick(8);
    cs_n_in = 1'b0; rd_n_in = 1'b0;
    tick(6);
    if (idle_high) begin
      sclk_in = 1'b0;   // R9: no shift expected here
      tick(8);
    end
    for (int i = 0; i < nbits; i++) begin
      -> samp_ev; #1;
      sclk_in = 1'b1;
      tick(8);
      -> samp_ev; #1;
      sclk_in = 1'b0;
      chain_in = up_s[47-(i+1)];
      tick(8);
    end
    if (idle_high) begin
      sclk_in = 1'b1;
      tick(8);
    end
    cs_n_in = 1'b1; rd_n_in = 1'b1;
    tick(4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    tick(3);
    chk(sdo_en === 1'b0, "R1 sdo_en", int'(sdo_en), 0);
    chk(sdo === 1'b0, "R1 sdo", int'(sdo), 0);
    chk(load_ready === 1'b1, "R1 load_ready", int'(load_ready), 1);
    rst_n = 1'b1;
    tick(3);

    // R2 R3: plain read, clock idle low
    load_word(16'hA5C3);
    do_read({16'hA5C3, 32'h0}, 48'h0, 16, 1'b0, "R2 R3 word");
    chk(sdo_en === 1'b0, "R4 disabled after read", int'(sdo_en), 0);

    // R9: clock resting high
    load_word(16'h3C71);
    do_read({16'h3C71, 32'h0}, 48'h0, 16, 1'b1, "R9 idle-high word");

    // R6: chain, upstream word follows local LSB
    load_word(16'h8001);
    do_read({16'h8001, 16'hBEEF, 16'h0}, {16'hBEEF, 32'h0}, 32, 1'b0, "R6 chain");

    // R5 and R4: edges while not selected leave word unchanged
    load_word(16'h5A96);
    cs_n_in = 1'b1; rd_n_in = 1'b0;
    for (int i = 0; i < 5; i++) begin
      sclk_in = 1'b1; tick(8); sclk_in = 1'b0; tick(8);
    end
    cs_n_in = 1'b0; rd_n_in = 1'b1;
    for (int i = 0; i < 5; i++) begin
      sclk_in = 1'b1; tick(8);
      chk(sdo_en === 1'b0, "R4 rd high disables", int'(sdo_en), 0);
      sclk_in = 1'b0; tick(8);
    end
    cs_n_in = 1'b1; rd_n_in = 1'b1;
    tick(4);
    do_read({16'h5A96, 32'h0}, 48'h0, 16, 1'b0, "R5 word kept");

    // R7 with same-cycle case: load valid across read start
    @(negedge clk);
    load_valid = 1'b1; load_data = 16'hC0DE;
    cs_n_in = 1'b0; rd_n_in = 1'b0;
    tick(3);
    chk(load_ready === 1'b0, "R7 ready low in read", int'(load_ready), 0);
    chk(sdo === 1'b1, "R2 msb of last accepted load", int'(sdo), 1);
    load_data = 16'h1234;
    tick(4);
    load_valid = 1'b0;
    do_read({16'hC0DE, 32'h0}, 48'h0, 16, 1'b0, "R7 rejected load");

    tick(4);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule